// File: doc/BRIEF.md
# Halt Power-State Sequencer

This controller decides when a two-thread processor core may drop into an idle power state, and it steps the core clock ratio and the regulator voltage code in a safe order on the way in and on the way out. Each thread raises a halt flag. Only when every thread has halted does the core leave the running state. Any of five wake sources then brings it back: system-management interrupt, init, bus-init, and two local interrupt lines. Reset is asynchronous and overrides everything.

A stop-clock request may arrive while the core is idle. It parks the controller in a stop-grant state. Releasing the request puts the controller back into the idle state it came from. When the enhanced enable is set, idle uses a deeper state instead of plain halt. On the way in, the core ratio drops first and the voltage code drops second. On the way out, the voltage code rises first and the ratio rises second. Each step is followed by a settle delay, given in cycles by an input. The running ratio and voltage values, and the idle ones, are captured from configuration inputs on every running cycle. They freeze once the running state is left. A return from the system-management handler can resume idle directly.

Top module: `halt_pwr_seq`

## Requirements
- R1: From the running state, idle is entered only when all bits of `thr_halt` are 1 (or R9 applies); with any thread still running the state stays running.
- R2: In plain halt, any wake source moves the state to running at the next clock edge. In the deep halt state, any wake source moves it to the exit sequence at the next edge. A wake source present in the running state blocks idle entry.
- R3: While `rst_n` is low, the outputs are forced at once to the running state with `core_ratio` = RST_RATIO, `vid_code` = RST_VID and `snoop_en` = 0.
- R4: In plain or deep halt, with no wake source present, `stpclk_req` moves the state to stop-grant at the next edge. Wake sources are ignored in stop-grant. The edge after the request drops, the state returns to the halt state it left.
- R5: With `enh_en` = 0, idle entry goes to plain halt and `core_ratio`/`vid_code` keep their running values; the deep sequence starts only with `enh_en` = 1.
- R6: With settle value S, take the edge that sees the entry condition as edge 1. `core_ratio` shows the idle ratio after edge 1. `vid_code` shows the idle voltage code after edge S+2. The deep halt state is reached after edge 2S+3.
- R7: Take the edge that sees a wake source in deep halt as edge 1. `vid_code` returns to its running value after edge 1. `core_ratio` returns after edge S+2. The running state is reached after edge 2S+3.
- R8: `snoop_en` is 1 exactly in plain halt and deep halt, and 0 in every other state.
- R9: In the running state, a `smi_rsm` pulse with `rsm_to_halt` = 1 enters idle (plain or deep per `enh_en`) regardless of `thr_halt`. With `rsm_to_halt` = 0 the state stays running.
- R10: A wake source during the entry sequence switches to the exit sequence at the next edge. Any settle delay still running is finished first. Only the steps already taken are undone, voltage before ratio, so a voltage code that was never lowered is never changed.
- R11: The values restored on exit are the configuration values of the last running cycle; configuration changes while idle have no effect on `core_ratio` or `vid_code` until running resumes.
- R12: `pstate` encodes running = 0, plain halt = 1, entry sequence = 2, deep halt = 3, exit sequence = 4, stop-grant = 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_halt | input | NUM_THREADS | Per-thread halt indication |
| evt_smi | input | 1 | System-management interrupt wake source |
| evt_init | input | 1 | Init wake source |
| evt_binit | input | 1 | Bus-init wake source |
| evt_lint | input | NUM_LINT | Local interrupt wake lines |
| stpclk_req | input | 1 | Stop-clock request |
| enh_en | input | 1 | Selects the deep halt state for idle |
| smi_rsm | input | 1 | Pulse: return from the system-management handler |
| rsm_to_halt | input | 1 | Resume target for `smi_rsm`: 1 = idle, 0 = running |
| settle_cycles | input | SETTLE_W | Settle delay after each ratio or voltage step |
| cfg_run_ratio | input | RATIO_W | Running core ratio |
| cfg_run_vid | input | VID_W | Running voltage code |
| cfg_idle_ratio | input | RATIO_W | Deep-halt core ratio |
| cfg_idle_vid | input | VID_W | Deep-halt voltage code |
| core_ratio | output | RATIO_W | Core clock ratio select |
| vid_code | output | VID_W | Voltage code to the regulator |
| pstate | output | 3 | Encoded current state (R12) |
| snoop_en | output | 1 | Snoop servicing active |

## Verification
Every transition and every step flag is registered once, so a state or output change appears one edge after the cycle whose inputs cause it. The exception is reset, which acts at once. Within the deep sequences the step edges fall at 1, S+2 and 2S+3 counted from the causing edge, and the bench checks each output in the cycle just before such an edge and in the cycle just after it. Inputs are driven on the falling edge and outputs are sampled on the next falling edge. A bench model advances once per rising edge from the same inputs, so the cycle-by-cycle comparison during the random phase keeps to the same timing.

// File: rtl/hps_pkg.sv
package hps_pkg;
   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_HALT    = 3'd1,
      ST_DN_SEQ  = 3'd2,
      ST_DEEP    = 3'd3,
      ST_UP_SEQ  = 3'd4,
      ST_STOPGNT = 3'd5
   } pstate_e;
endpackage

// File: rtl/hps_wake_merge.sv
module hps_wake_merge #(
   parameter int NUM_LINT = 2
) (
   input  logic                evt_smi,
   input  logic                evt_init,
   input  logic                evt_binit,
   input  logic [NUM_LINT-1:0] evt_lint,
   output logic                wake
);
   logic [NUM_LINT:0] chain;
   assign chain[0] = evt_smi | evt_init | evt_binit;
   for (genvar g = 0; g < NUM_LINT; g++) begin : g_lint
      assign chain[g+1] = chain[g] | evt_lint[g];
   end
   assign wake = chain[NUM_LINT];
endmodule

// File: rtl/hps_settle_timer.sv
module hps_settle_timer #(
   parameter int SETTLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [SETTLE_W-1:0] load_val,
   output logic                zero
);
   logic [SETTLE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   p_settle_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !zero);
endmodule

// File: rtl/hps_op_point.sv
module hps_op_point #(
   parameter int                RATIO_W   = 6,
   parameter int                VID_W     = 8,
   parameter logic [RATIO_W-1:0] RST_RATIO = '0,
   parameter logic [VID_W-1:0]   RST_VID   = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic               ratio_lo,
   input  logic               vid_lo,
   input  logic [RATIO_W-1:0] cfg_run_ratio,
   input  logic [VID_W-1:0]   cfg_run_vid,
   input  logic [RATIO_W-1:0] cfg_idle_ratio,
   input  logic [VID_W-1:0]   cfg_idle_vid,
   output logic [RATIO_W-1:0] core_ratio,
   output logic [VID_W-1:0]   vid_code
);
   logic [RATIO_W-1:0] run_ratio_q, idle_ratio_q;
   logic [VID_W-1:0]   run_vid_q, idle_vid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_ratio_q  <= RST_RATIO;
         idle_ratio_q <= RST_RATIO;
         run_vid_q    <= RST_VID;
         idle_vid_q   <= RST_VID;
      end else if (capture) begin
         run_ratio_q  <= cfg_run_ratio;
         idle_ratio_q <= cfg_idle_ratio;
         run_vid_q    <= cfg_run_vid;
         idle_vid_q   <= cfg_idle_vid;
      end
   end

   assign core_ratio = ratio_lo ? idle_ratio_q : run_ratio_q;
   assign vid_code   = vid_lo   ? idle_vid_q   : run_vid_q;

   p_frozen_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!capture && !ratio_lo && !vid_lo) |=> (!capture || $stable(run_ratio_q)));
endmodule

// File: rtl/halt_pwr_seq.sv
module halt_pwr_seq
   import hps_pkg::*;
#(
   parameter int                 NUM_THREADS = 2,
   parameter int                 NUM_LINT    = 2,
   parameter int                 SETTLE_W    = 8,
   parameter int                 RATIO_W     = 6,
   parameter int                 VID_W       = 8,
   parameter logic [RATIO_W-1:0] RST_RATIO   = 6'd20,
   parameter logic [VID_W-1:0]   RST_VID     = 8'h30
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] thr_halt,
   input  logic                   evt_smi,
   input  logic                   evt_init,
   input  logic                   evt_binit,
   input  logic [NUM_LINT-1:0]    evt_lint,
   input  logic                   stpclk_req,
   input  logic                   enh_en,
   input  logic                   smi_rsm,
   input  logic                   rsm_to_halt,
   input  logic [SETTLE_W-1:0]    settle_cycles,
   input  logic [RATIO_W-1:0]     cfg_run_ratio,
   input  logic [VID_W-1:0]       cfg_run_vid,
   input  logic [RATIO_W-1:0]     cfg_idle_ratio,
   input  logic [VID_W-1:0]       cfg_idle_vid,
   output logic [RATIO_W-1:0]     core_ratio,
   output logic [VID_W-1:0]       vid_code,
   output logic [2:0]             pstate,
   output logic                   snoop_en
);
   if (NUM_THREADS < 1) begin : g_bad_threads
      $error("halt_pwr_seq: NUM_THREADS must be at least 1");
   end
   if (NUM_LINT < 1) begin : g_bad_lint
      $error("halt_pwr_seq: NUM_LINT must be at least 1");
   end
   if (SETTLE_W < 1 || RATIO_W < 1 || VID_W < 1) begin : g_bad_width
      $error("halt_pwr_seq: widths must be positive");
   end

   pstate_e state_q, state_d;
   logic    rlo_q, rlo_d, vlo_q, vlo_d, ret_deep_q, ret_deep_d;
   logic    tload, tzero, wake, go_idle;

   hps_wake_merge #(.NUM_LINT(NUM_LINT)) u_wake (
      .evt_smi(evt_smi), .evt_init(evt_init), .evt_binit(evt_binit),
      .evt_lint(evt_lint), .wake(wake));

   hps_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tload), .load_val(settle_cycles),
      .zero(tzero));

   hps_op_point #(.RATIO_W(RATIO_W), .VID_W(VID_W),
                  .RST_RATIO(RST_RATIO), .RST_VID(RST_VID)) u_op (
      .clk(clk), .rst_n(rst_n), .capture(state_q == ST_RUN),
      .ratio_lo(rlo_q), .vid_lo(vlo_q),
      .cfg_run_ratio(cfg_run_ratio), .cfg_run_vid(cfg_run_vid),
      .cfg_idle_ratio(cfg_idle_ratio), .cfg_idle_vid(cfg_idle_vid),
      .core_ratio(core_ratio), .vid_code(vid_code));

   assign go_idle = (&thr_halt) | (smi_rsm & rsm_to_halt);

   always_comb begin
      state_d    = state_q;
      rlo_d      = rlo_q;
      vlo_d      = vlo_q;
      ret_deep_d = ret_deep_q;
      tload      = 1'b0;
      unique case (state_q)
         ST_RUN: begin
            if (!wake && go_idle) begin
               if (enh_en) begin
                  state_d = ST_DN_SEQ;
                  rlo_d   = 1'b1;
                  tload   = 1'b1;
               end else begin
                  state_d = ST_HALT;
               end
            end
         end
         ST_HALT: begin
            if (wake) state_d = ST_RUN;
            else if (stpclk_req) begin
               state_d    = ST_STOPGNT;
               ret_deep_d = 1'b0;
            end
         end
         ST_DN_SEQ: begin
            if (wake) state_d = ST_UP_SEQ;
            else if (tzero) begin
               if (!vlo_q) begin
                  vlo_d = 1'b1;
                  tload = 1'b1;
               end else begin
                  state_d = ST_DEEP;
               end
            end
         end
         ST_DEEP: begin
            if (wake) begin
               state_d = ST_UP_SEQ;
               vlo_d   = 1'b0;
               tload   = 1'b1;
            end else if (stpclk_req) begin
               state_d    = ST_STOPGNT;
               ret_deep_d = 1'b1;
            end
         end
         ST_UP_SEQ: begin
            if (tzero) begin
               if (vlo_q) begin
                  vlo_d = 1'b0;
                  tload = 1'b1;
               end else if (rlo_q) begin
                  rlo_d = 1'b0;
                  tload = 1'b1;
               end else begin
                  state_d = ST_RUN;
               end
            end
         end
         ST_STOPGNT: begin
            if (!stpclk_req) state_d = ret_deep_q ? ST_DEEP : ST_HALT;
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_RUN;
         rlo_q      <= 1'b0;
         vlo_q      <= 1'b0;
         ret_deep_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         rlo_q      <= rlo_d;
         vlo_q      <= vlo_d;
         ret_deep_q <= ret_deep_d;
      end
   end

   assign pstate   = state_q;
   assign snoop_en = (state_q == ST_HALT) || (state_q == ST_DEEP);

   p_all_threads_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 3'd0 && !(&thr_halt) && !(smi_rsm && rsm_to_halt)) |=> pstate == 3'd0);
   p_wake_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 3'd1 && wake) |=> pstate == 3'd0);
   p_wake_deep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 3'd3 && wake) |=> pstate == 3'd4);
   p_stopclk_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 3'd5 && !stpclk_req) |=> (pstate == 3'd1 || pstate == 3'd3));
   p_plain_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 3'd0 && !enh_en) |=> pstate != 3'd2);
   p_ratio_then_vid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vlo_q) |-> $past(rlo_q));
   p_vid_then_ratio_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rlo_q) |-> !$past(vlo_q));
   p_legal_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pstate <= 3'd5);
endmodule

// File: tb/halt_pwr_seq_tb.sv
module halt_pwr_seq_tb;
   localparam logic [5:0] RSTR = 6'd20;
   localparam logic [7:0] RSTV = 8'h30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] thr_halt = '0;
   logic       evt_smi = 0, evt_init = 0, evt_binit = 0;
   logic [1:0] evt_lint = '0;
   logic       stpclk_req = 0, enh_en = 0, smi_rsm = 0, rsm_to_halt = 0;
   logic [7:0] settle_cycles = 8'd3;
   logic [5:0] cfg_run_ratio = 6'd36, cfg_idle_ratio = 6'd14;
   logic [7:0] cfg_run_vid = 8'hA4, cfg_idle_vid = 8'h52;
   logic [5:0] core_ratio;
   logic [7:0] vid_code;
   logic [2:0] pstate;
   logic       snoop_en;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // model state
   int         m_st;
   bit         m_rlo, m_vlo, m_ret;
   int         m_cnt;
   logic [5:0] m_rr, m_ir;
   logic [7:0] m_rv, m_iv;

   always #5 clk = ~clk;

   halt_pwr_seq u_dut (
      .clk(clk), .rst_n(rst_n), .thr_halt(thr_halt),
      .evt_smi(evt_smi), .evt_init(evt_init), .evt_binit(evt_binit),
      .evt_lint(evt_lint), .stpclk_req(stpclk_req), .enh_en(enh_en),
      .smi_rsm(smi_rsm), .rsm_to_halt(rsm_to_halt),
      .settle_cycles(settle_cycles),
      .cfg_run_ratio(cfg_run_ratio), .cfg_run_vid(cfg_run_vid),
      .cfg_idle_ratio(cfg_idle_ratio), .cfg_idle_vid(cfg_idle_vid),
      .core_ratio(core_ratio), .vid_code(vid_code), .pstate(pstate),
      .snoop_en(snoop_en));

   task automatic chk(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_st = 0; m_rlo = 0; m_vlo = 0; m_ret = 0; m_cnt = 0;
      m_rr = RSTR; m_ir = RSTR; m_rv = RSTV; m_iv = RSTV;
   endtask

   // one rising edge of the requirement model (R1..R12)
   task automatic model_step();
      bit wk, ld;
      int ns;
      wk = evt_smi | evt_init | evt_binit | (|evt_lint);
      ld = 0; ns = m_st;
      case (m_st)
         0: if (!wk && ((&thr_halt) || (smi_rsm && rsm_to_halt))) begin
               if (enh_en) begin ns = 2; m_rlo = 1; ld = 1; end
               else ns = 1;
            end
         1: if (wk) ns = 0; else if (stpclk_req) begin ns = 5; m_ret = 0; end
         2: if (wk) ns = 4;
            else if (m_cnt == 0) begin
               if (!m_vlo) begin m_vlo = 1; ld = 1; end else ns = 3;
            end
         3: if (wk) begin ns = 4; m_vlo = 0; ld = 1; end
            else if (stpclk_req) begin ns = 5; m_ret = 1; end
         4: if (m_cnt == 0) begin
               if (m_vlo) begin m_vlo = 0; ld = 1; end
               else if (m_rlo) begin m_rlo = 0; ld = 1; end
               else ns = 0;
            end
         default: if (!stpclk_req) ns = m_ret ? 3 : 1;
      endcase
      if (m_st == 0) begin
         m_rr = cfg_run_ratio; m_ir = cfg_idle_ratio;
         m_rv = cfg_run_vid;   m_iv = cfg_idle_vid;
      end
      if (ld) m_cnt = settle_cycles;
      else if (m_cnt != 0) m_cnt--;
      m_st = ns;
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk("R12 state vs model", pstate, m_st);
      chk("R6 ratio vs model", core_ratio, m_rlo ? m_ir : m_rr);
      chk("R7 vid vs model", vid_code, m_vlo ? m_iv : m_rv);
      chk("R8 snoop vs model", snoop_en, (m_st == 1 || m_st == 3));
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'd20240517));
      model_reset();
      repeat (3) @(negedge clk);
      // R3 reset values
      chk("R3 reset state", pstate, 0);
      chk("R3 reset ratio", core_ratio, RSTR);
      chk("R3 reset vid", vid_code, RSTV);
      chk("R3 reset snoop", snoop_en, 0);
      rst_n = 1'b1;
      tick(); tick();

      // R1 one thread only
      thr_halt = 2'b01;
      repeat (5) tick();
      chk("R1 single thread stays running", pstate, 0);

      // R5 plain halt
      thr_halt = 2'b11; enh_en = 0;
      tick();
      chk("R5 plain halt entered", pstate, 1);
      chk("R8 snoop in halt", snoop_en, 1);
      chk("R5 ratio unchanged", core_ratio, 36);
      chk("R5 vid unchanged", vid_code, 8'hA4);

      // R4 stop clock, wake ignored
      stpclk_req = 1; tick();
      chk("R4 stop-grant", pstate, 5);
      chk("R8 no snoop in stop-grant", snoop_en, 0);
      evt_init = 1; tick(); evt_init = 0;
      chk("R4 wake ignored in stop-grant", pstate, 5);
      stpclk_req = 0; tick();
      chk("R4 back to plain halt", pstate, 1);

      // R2 local interrupt wakes
      evt_lint = 2'b10; thr_halt = 2'b00; tick(); evt_lint = 0;
      chk("R2 wake to running", pstate, 0);
      tick();

      // R6 deep entry with S=3
      enh_en = 1; thr_halt = 2'b11; tick();
      chk("R6 entry state", pstate, 2);
      chk("R6 ratio lowered at edge 1", core_ratio, 14);
      chk("R6 vid still high at edge 1", vid_code, 8'hA4);
      repeat (3) tick();
      chk("R6 vid high at edge S+1", vid_code, 8'hA4);
      tick();
      chk("R6 vid low at edge S+2", vid_code, 8'h52);
      repeat (3) tick();
      chk("R6 still entering at 2S+2", pstate, 2);
      tick();
      chk("R6 deep reached at 2S+3", pstate, 3);
      chk("R8 snoop in deep", snoop_en, 1);

      // R4 from deep, R11 cfg change while idle
      stpclk_req = 1; tick(); stpclk_req = 0; tick();
      chk("R4 back to deep", pstate, 3);
      cfg_run_ratio = 6'd40; cfg_run_vid = 8'hC0; tick();
      chk("R11 idle ratio frozen", core_ratio, 14);

      // R7 exit
      evt_smi = 1; thr_halt = 2'b00; tick(); evt_smi = 0;
      chk("R7 exit state", pstate, 4);
      chk("R7 vid restored at edge 1", vid_code, 8'hA4);
      chk("R7 ratio still low at edge 1", core_ratio, 14);
      repeat (3) tick();
      chk("R7 ratio low at edge S+1", core_ratio, 14);
      tick();
      chk("R11 ratio restored to latched value", core_ratio, 36);
      repeat (3) tick();
      chk("R7 exiting at 2S+2", pstate, 4);
      tick();
      chk("R7 running at 2S+3", pstate, 0);
      tick();
      chk("R11 new cfg taken when running", core_ratio, 40);

      // R10 abort during entry
      thr_halt = 2'b11; tick();
      evt_binit = 1; thr_halt = 2'b00; tick(); evt_binit = 0;
      chk("R10 abort to exit", pstate, 4);
      for (int i = 0; i < 8; i++) begin
         chk("R10 vid never lowered", vid_code, 8'hC0);
         tick();
      end
      chk("R10 running after abort", pstate, 0);
      chk("R10 ratio restored", core_ratio, 40);

      // R9 handler return
      smi_rsm = 1; rsm_to_halt = 0; tick(); smi_rsm = 0;
      chk("R9 resume to running", pstate, 0);
      enh_en = 0; smi_rsm = 1; rsm_to_halt = 1; tick(); smi_rsm = 0;
      chk("R9 resume to halt", pstate, 1);
      evt_smi = 1; tick(); evt_smi = 0;
      chk("R2 smi wakes", pstate, 0);

      // R3 async reset mid deep sequence
      enh_en = 1; thr_halt = 2'b11; repeat (3) tick();
      #1 rst_n = 1'b0; #1;
      chk("R3 async state", pstate, 0);
      chk("R3 async ratio", core_ratio, RSTR);
      chk("R3 async vid", vid_code, RSTV);
      model_reset();
      @(negedge clk); thr_halt = 0; rst_n = 1'b1;

      // random phase
      for (int c = 0; c < 3000; c++) begin
         if ($urandom % 5 == 0) thr_halt = 2'($urandom);
         else if ($urandom % 3 == 0) thr_halt = 2'b11;
         evt_smi   = ($urandom % 40 == 0);
         evt_init  = ($urandom % 40 == 0);
         evt_binit = ($urandom % 40 == 0);
         evt_lint  = ($urandom % 20 == 0) ? 2'($urandom) : 2'b00;
         if ($urandom % 20 == 0) stpclk_req = ~stpclk_req;
         if ($urandom % 50 == 0) enh_en = ~enh_en;
         smi_rsm = ($urandom % 30 == 0);
         rsm_to_halt = 1'($urandom);
         if ($urandom % 40 == 0) settle_cycles = 8'($urandom % 4);
         if ($urandom % 25 == 0) begin
            cfg_run_ratio = 6'($urandom); cfg_idle_ratio = 6'($urandom);
            cfg_run_vid = 8'($urandom);   cfg_idle_vid = 8'($urandom);
         end
         tick();
      end
      summary();
   end
endmodule